// File: doc/BRIEF.md
# Period Counter with Selectable Resets

This block is the counting core of a PWM timing unit. A 16-bit up-counter advances once per prescaled tick. The tick rate is the base clock divided by a power of two from 1 to 128. When the counter reaches the active period, the next tick takes it back to zero and produces a roll-over pulse. On each roll-over the block copies the preloaded period and compare values into the active registers and steps a repetition counter. When the repetition counter has run down, it reloads and produces its own pulse.

A counter clear can come from a software request or from any of 30 event lines, each gated by its own mask bit. A request that arrives between ticks is held and applied on the next tick. This keeps edges that are timed from a clear aligned to the counting grid. Requests are dropped while the counter is disabled. If the counter sits above the period, because it was stopped there or because the period was lowered beneath it, it runs on to full scale and wraps without a roll-over.

Top module: `period_timer`

## Requirements
- R1: While `cnt_en` is 1, the counter rises by one on every tick, and a tick occurs once every 2^`psc_sel` clock cycles. While `cnt_en` is 0 the counter holds its value and the prescaler restarts.
- R2: On a tick where the counter equals the active period, the counter becomes 0 and `rollover` is 1 for exactly that one cycle. The pulse is in the same cycle in which `cnt_val` first reads 0.
- R3: When `pre_en` is 1 and the counter is enabled, the active period and compare values take the preload values only on a roll-over. When `pre_en` is 0 or the counter is disabled, they follow the preload inputs one cycle later.
- R4: Each roll-over decrements `rep_val`. A roll-over that finds `rep_val` at 0 reloads it from `rep_pre` and raises `rep_evt` in the same cycle as `rollover`. While the counter is disabled, `rep_val` follows `rep_pre`. Otherwise `rep_val` changes only on a roll-over.
- R5: When the counter is above the active period, it counts on to 65535 and then wraps to 0 with no `rollover`, no `rep_evt` and no change to `rep_val`.
- R6: The clear request is `sw_rst` OR any bit of `evt_in & evt_mask`, where bit i of `evt_mask` enables line i. A clear that is applied sets the counter to 0 and pulses `rst_evt` for one cycle. It takes priority over a roll-over, produces no `rollover`, and leaves `rep_val` unchanged.
- R7: Requests that arrive together, or anywhere in the same tick interval, produce a single clear and a single `rst_evt` pulse.
- R8: While `cnt_en` is 0, clear requests are neither applied nor remembered.
- R9: A request that arrives between ticks is held. It is applied on the next tick, which with a divide-by-8 tick is 8 cycles after a request raised just after a tick.
- R10: During reset, the counter, the active registers, the repetition count and all pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter enable |
| pre_en | input | 1 | 1: preload values transfer on roll-over; 0: they pass straight through |
| psc_sel | input | 3 | Tick divider exponent; the divide ratio is 2^psc_sel |
| per_pre | input | 16 | Preload period |
| cmp_pre | input | 16 | Preload compare value |
| rep_pre | input | 8 | Preload repetition count |
| evt_in | input | 30 | Clear event lines |
| evt_mask | input | 30 | Per-line enable for evt_in |
| sw_rst | input | 1 | Software clear request |
| cnt_val | output | 16 | Counter value |
| per_act | output | 16 | Active period |
| cmp_act | output | 16 | Active compare value |
| rep_val | output | 8 | Repetition counter |
| rollover | output | 1 | One-cycle roll-over pulse |
| rep_evt | output | 1 | One-cycle repetition-underflow pulse |
| rst_evt | output | 1 | One-cycle clear pulse |

## Verification
Every result is registered, so a tick at a rising edge appears in the counter value, in `rollover`, `rep_evt` and `rst_evt`, and in the active registers in the cycle that follows that edge. The one exception is a held clear: it appears only at the edge of the next tick, up to 2^`psc_sel` cycles after the request. The reference model in the bench updates on the same edge as the design, and the bench compares the two half a cycle later. The directed checks count edges from a known tick phase: for example, 7 edges after a divide-by-8 tick the clear must still be pending, and it must have taken effect on the 8th.

// File: rtl/tm_pkg.sv
package tm_pkg;
    // what the counter does on a given clock
    typedef enum logic [1:0] {
        TK_IDLE,
        TK_COUNT,
        TK_WRAP,
        TK_CLEAR
    } tick_act_e;
endpackage

// File: rtl/tm_prescaler.sv
module tm_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < int'(sel));
        end
        tick  = run && ((div_q & mask) == mask);
        div_d = run ? div_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/tm_rst_collect.sv
module tm_rst_collect #(
    parameter int N_EVT = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [N_EVT-1:0] evt,
    input  logic [N_EVT-1:0] msk,
    input  logic             sw,
    output logic             apply
);
    logic [N_EVT-1:0] hit;
    logic             req;
    logic             pend_d, pend_q;

    for (genvar g = 0; g < N_EVT; g++) begin : g_line
        assign hit[g] = evt[g] & msk[g];
    end

    always_comb begin
        req    = sw || (|hit);
        apply  = en && tick && (pend_q || req);
        if (!en)        pend_d = 1'b0;
        else if (apply) pend_d = 1'b0;
        else            pend_d = pend_q || req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/tm_rep_count.sv
module tm_rep_count #(
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             roll,
    input  logic [REP_W-1:0] rep_pre,
    output logic [REP_W-1:0] rep_val,
    output logic             rep_evt
);
    typedef struct packed {
        logic [REP_W-1:0] val;
        logic             evt;
    } rep_st_t;

    rep_st_t rep_d, rep_q;

    always_comb begin
        rep_d     = rep_q;
        rep_d.evt = 1'b0;
        if (!en) begin
            rep_d.val = rep_pre;
        end else if (roll) begin
            if (rep_q.val == '0) begin
                rep_d.val = rep_pre;
                rep_d.evt = 1'b1;
            end else begin
                rep_d.val = rep_q.val - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rep_q <= '0;
        else        rep_q <= rep_d;
    end

    assign rep_val = rep_q.val;
    assign rep_evt = rep_q.evt;
endmodule

// File: rtl/period_timer.sv
module period_timer #(
    parameter int CNT_W = 16,
    parameter int REP_W = 8,
    parameter int SEL_W = 3,
    parameter int N_EVT = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             pre_en,
    input  logic [SEL_W-1:0] psc_sel,
    input  logic [CNT_W-1:0] per_pre,
    input  logic [CNT_W-1:0] cmp_pre,
    input  logic [REP_W-1:0] rep_pre,
    input  logic [N_EVT-1:0] evt_in,
    input  logic [N_EVT-1:0] evt_mask,
    input  logic             sw_rst,
    output logic [CNT_W-1:0] cnt_val,
    output logic [CNT_W-1:0] per_act,
    output logic [CNT_W-1:0] cmp_act,
    output logic [REP_W-1:0] rep_val,
    output logic             rollover,
    output logic             rep_evt,
    output logic             rst_evt
);
    import tm_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] cmp;
        logic             roll;
        logic             clr;
    } core_st_t;

    core_st_t  core_d, core_q;
    tick_act_e act;
    logic      tick;
    logic      clr_apply;
    logic      wrap_now;

    tm_prescaler #(.SEL_W(SEL_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cnt_en),
        .sel   (psc_sel),
        .tick  (tick)
    );

    tm_rst_collect #(.N_EVT(N_EVT)) u_clr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cnt_en),
        .tick  (tick),
        .evt   (evt_in),
        .msk   (evt_mask),
        .sw    (sw_rst),
        .apply (clr_apply)
    );

    always_comb begin
        act = TK_IDLE;
        if (cnt_en && tick) begin
            if (clr_apply)                   act = TK_CLEAR;
            else if (core_q.cnt == core_q.per) act = TK_WRAP;
            else                             act = TK_COUNT;
        end
        wrap_now = (act == TK_WRAP);
    end

    always_comb begin
        core_d      = core_q;
        core_d.roll = 1'b0;
        core_d.clr  = 1'b0;
        unique case (act)
            TK_CLEAR: begin
                core_d.cnt = '0;
                core_d.clr = 1'b1;
            end
            TK_WRAP: begin
                core_d.cnt  = '0;
                core_d.roll = 1'b1;
            end
            TK_COUNT: core_d.cnt = core_q.cnt + 1'b1;
            default:  ;
        endcase
        if (!cnt_en || !pre_en || wrap_now) begin
            core_d.per = per_pre;
            core_d.cmp = cmp_pre;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    tm_rep_count #(.REP_W(REP_W)) u_rep (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cnt_en),
        .roll    (wrap_now),
        .rep_pre (rep_pre),
        .rep_val (rep_val),
        .rep_evt (rep_evt)
    );

    assign cnt_val  = core_q.cnt;
    assign per_act  = core_q.per;
    assign cmp_act  = core_q.cmp;
    assign rollover = core_q.roll;
    assign rst_evt  = core_q.clr;
endmodule

// File: rtl/tm_checker.sv
module tm_checker #(
    parameter int CNT_W = 16,
    parameter int REP_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic [CNT_W-1:0] cnt_val,
    input logic [REP_W-1:0] rep_val,
    input logic             rollover,
    input logic             rep_evt,
    input logic             rst_evt
);
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en |=> (cnt_val == $past(cnt_val) || cnt_val == $past(cnt_val) + 1'b1 || cnt_val == '0));

    p_hold_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(cnt_val));

    p_roll_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rollover |-> cnt_val == '0);

    p_rep_with_roll_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rep_evt |-> rollover);

    p_rep_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_en) && !rollover) |-> $stable(rep_val));

    p_clr_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt |-> (cnt_val == '0 && !rollover));

    p_quiet_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cnt_en) |-> (!rst_evt && !rollover));
endmodule

bind period_timer tm_checker #(.CNT_W(CNT_W), .REP_W(REP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .cnt_val  (cnt_val),
    .rep_val  (rep_val),
    .rollover (rollover),
    .rep_evt  (rep_evt),
    .rst_evt  (rst_evt)
);

// File: tb/sim_period_timer.sv
module sim_period_timer;
    localparam int CLK_NS = 10;
    localparam int LIMIT  = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0, pre_en = 1'b0, sw_rst = 1'b0;
    logic [2:0]  psc_sel = '0;
    logic [15:0] per_pre = '0, cmp_pre = '0;
    logic [7:0]  rep_pre = '0;
    logic [29:0] evt_in = '0, evt_mask = '0;
    logic [15:0] cnt_val, per_act, cmp_act;
    logic [7:0]  rep_val;
    logic        rollover, rep_evt, rst_evt;

    int total = 0, bad = 0, cycles = 0;
    int n_roll = 0, n_rep = 0, n_rst = 0;
    bit done = 0;

    // reference model state
    int m_cnt = 0, m_per = 0, m_cmp = 0, m_rep = 0, m_psc = 0;
    bit m_pend = 0, m_roll = 0, m_repe = 0, m_clr = 0;

    always #(CLK_NS/2) clk = ~clk;

    period_timer u0 (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .pre_en(pre_en),
        .psc_sel(psc_sel), .per_pre(per_pre), .cmp_pre(cmp_pre),
        .rep_pre(rep_pre), .evt_in(evt_in), .evt_mask(evt_mask),
        .sw_rst(sw_rst), .cnt_val(cnt_val), .per_act(per_act),
        .cmp_act(cmp_act), .rep_val(rep_val), .rollover(rollover),
        .rep_evt(rep_evt), .rst_evt(rst_evt)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_per = 0; m_cmp = 0; m_rep = 0; m_psc = 0;
            m_pend = 0; m_roll = 0; m_repe = 0; m_clr = 0;
        end else begin
            int  span;
            bit  tk, req, app, rl;
            span = (1 << psc_sel);
            tk   = cnt_en && ((m_psc % span) == span - 1);
            req  = sw_rst || ((evt_in & evt_mask) != 0);
            app  = cnt_en && tk && (m_pend || req);
            rl   = 0;
            m_clr = 0; m_repe = 0;
            if (cnt_en && tk) begin
                if (app) begin m_cnt = 0; m_clr = 1; end
                else if (m_cnt == m_per) begin m_cnt = 0; rl = 1; end
                else m_cnt = (m_cnt + 1) % 65536;
            end
            m_roll = rl;
            m_pend = cnt_en ? (app ? 0 : (m_pend || req)) : 0;
            if (!cnt_en) m_rep = rep_pre;
            else if (rl) begin
                if (m_rep == 0) begin m_rep = rep_pre; m_repe = 1; end
                else m_rep = m_rep - 1;
            end
            if (!cnt_en || !pre_en || rl) begin m_per = per_pre; m_cmp = cmp_pre; end
            m_psc = cnt_en ? (m_psc + 1) % 128 : 0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // compare against the model on every cycle, away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cycles++;
            check("R1 cnt_val", int'(cnt_val), m_cnt);
            check("R2 rollover", int'(rollover), int'(m_roll));
            check("R3 per_act", int'(per_act), m_per);
            check("R3 cmp_act", int'(cmp_act), m_cmp);
            check("R4 rep_val", int'(rep_val), m_rep);
            check("R4 rep_evt", int'(rep_evt), int'(m_repe));
            check("R6 rst_evt", int'(rst_evt), int'(m_clr));
            n_roll += int'(rollover);
            n_rep  += int'(rep_evt);
            n_rst  += int'(rst_evt);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        int r0, p0, c0, prev, guard;
        int rep0;
        step(3);
        // R10 reset state
        check("R10 cnt", int'(cnt_val), 0);
        check("R10 per", int'(per_act), 0);
        check("R10 rep", int'(rep_val), 0);
        check("R10 pulses", int'({rollover, rep_evt, rst_evt}), 0);
        rst_n = 1'b1;

        // R3: active values follow preload while disabled
        per_pre = 16'd5; cmp_pre = 16'd2; rep_pre = 8'd2; pre_en = 1'b1;
        step(2);
        check("R3 per follows while off", int'(per_act), 5);
        check("R4 rep follows while off", int'(rep_val), 2);

        // R2/R4: divide-by-1, period 5
        cnt_en = 1'b1;
        r0 = n_roll; p0 = n_rep;
        step(36);
        check("R2 six wraps in 36 ticks", n_roll - r0, 6);
        check("R4 two underflows", n_rep - p0, 2);

        // R3: new preload waits for a wrap
        per_pre = 16'd3;
        step(1);
        check("R3 per held until wrap", int'(per_act), 5);
        step(12);
        check("R3 per after wrap", int'(per_act), 3);
        per_pre = 16'd5;
        step(10);

        // R1: divide-by-4, 48 cycles = 12 ticks = 2 wraps of period 5
        psc_sel = 3'd2;
        step(1);
        r0 = n_roll;
        step(48);
        check("R1 wraps at div4", n_roll - r0, 2);

        // R5: lower period below counter, pass-through preload
        psc_sel = 3'd0; pre_en = 1'b0; per_pre = 16'd200;
        guard = 0;
        while (cnt_val != 16'd150 && guard < 1000) begin step(1); guard++; end
        per_pre = 16'd100;
        r0 = n_roll; p0 = n_rep; rep0 = int'(rep_val);
        step(2);
        guard = 0;
        while (cnt_val != 16'd0 && guard < 70000) begin step(1); guard++; end
        check("R5 reached full-scale wrap", int'(cnt_val), 0);
        check("R5 no rollover on wrap", n_roll - r0, 0);
        check("R5 rep untouched", int'(rep_val), rep0);
        step(100);
        check("R5 no wrap before period", n_roll - r0, 0);
        step(1);
        check("R5 wrap at period after overflow", n_roll - r0, 1);

        // R6: masked event lines
        pre_en = 1'b1; per_pre = 16'd50; evt_mask = 30'd1 << 3;
        step(20);
        c0 = n_rst; r0 = n_roll; rep0 = int'(rep_val);
        evt_in = (30'd1 << 3) | (30'd1 << 7);
        step(1);
        evt_in = '0;
        check("R6 enabled line clears", n_rst - c0, 1);
        check("R6 counter cleared", int'(cnt_val), 0);
        check("R6 rep unchanged", int'(rep_val), rep0);
        check("R6 no rollover", n_roll - r0, 0);
        step(5);
        c0 = n_rst;
        evt_in = 30'd1 << 7;
        step(1);
        evt_in = '0;
        step(1);
        check("R6 masked line ignored", n_rst - c0, 0);
        check("R6 counter kept running", int'(cnt_val), 7);

        // R7: simultaneous sources give one clear
        evt_mask = '1; step(3);
        c0 = n_rst;
        evt_in = '1; sw_rst = 1'b1;
        step(1);
        evt_in = '0; sw_rst = 1'b0;
        step(3);
        check("R7 single clear pulse", n_rst - c0, 1);

        // R8: requests while disabled are dropped
        cnt_en = 1'b0; step(1);
        c0 = n_rst; prev = int'(cnt_val);
        sw_rst = 1'b1; step(3); sw_rst = 1'b0;
        step(1);
        cnt_en = 1'b1;
        step(4);
        check("R8 no clear after re-enable", n_rst - c0, 0);
        check("R8 counter resumed", int'(cnt_val), (prev + 4) % 51);

        // R9: held to the next divide-by-8 tick; R7 two requests one clear
        psc_sel = 3'd3;
        step(20);
        prev = int'(cnt_val); guard = 0;
        while (int'(cnt_val) == prev && guard < 20) begin step(1); guard++; end
        c0 = n_rst;
        sw_rst = 1'b1; step(1); sw_rst = 1'b0;
        step(2);
        evt_in = 30'd1; step(1); evt_in = '0;
        step(3);
        check("R9 still pending after 7 edges", n_rst - c0, 0);
        step(1);
        check("R9 applied on 8th edge", n_rst - c0, 1);
        check("R9 counter cleared", int'(cnt_val), 0);
        step(16);
        check("R7 one clear per interval", n_rst - c0, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", LIMIT, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule